// File: doc/BRIEF.md
# Message-Signalled Interrupt Address Generator

This block turns pending interrupt sources into memory write requests for an interrupt delivery fabric that uses message writes. Every cycle it looks for sources that are enabled and pending while the domain enable pin is high. It picks one of them, clears its pending state through a one-cycle clear pulse, and emits a write request. The request carries a 64-bit physical address and the source's 11-bit identity as data. The address is built from two configuration words and from the hart and guest fields held in that source's target word. The high configuration word can be locked. A software message register can also send a write directly. Software supplies the hart and identity in it, and the guest field is always 0.

Configuration is written through a simple register port. The selected register is read back combinationally on `cfg_rdata`. Register selects are: 0 for the low base word, 1 for the high configuration word, 2 for the software message register, and `TGT_BASE + s` for the target word of source `s`. Requests leave through a valid/ready pair. A request is presented with `req_valid` and stays unchanged until a cycle in which `req_ready` is high at the clock edge. The block takes no new work while a request is outstanding. The next request can therefore appear no earlier than the cycle after the one that was accepted.

Top module: `msi_addr_gen`

## Requirements
- R1: All configuration, message and target registers reset to 0. A write to select 1 stores the value ANDed with 0x9F77FFFF. The selected register reads back on `cfg_rdata`.
- R2: When bit 31 of the high word is set, writes to selects 0 and 1 are ignored. Only reset clears the bit.
- R3: High word fields are: group shift in bits 28:24, hart shift in bits 22:20, group width in bits 18:16, hart width in bits 15:12, and upper base in bits 11:0. The group is the hart index shifted right by the hart width, then masked to the group width. The page number is the OR of four terms: {upper base, low word}; the group shifted left by (group shift + 12); the hart index masked to the hart width and shifted left by the hart shift; and the guest masked to the hart-shift width. `req_addr` is the page number shifted left by 12.
- R4: A target word holds the hart index in bits 31:18, the guest in bits 17:12 and the identity in bits 10:0. `req_data` is the identity zero-extended to 32 bits.
- R5: A source is issued only while `dom_en`, its `src_en` bit and its `src_pend` bit are all high. In the cycle it is issued, exactly its `pend_clr` bit is high.
- R6: When several sources qualify, one is issued per accepted request, in ascending source number. A `pend_clr` pulse is followed by `req_valid` in the next cycle.
- R7: Source 0 is never issued.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_data` hold. Configuration writes made during the wait do not alter the held request.
- R9: With `MACHINE_LEVEL` = 1 the guest used in the address is always 0.
- R10: A write to select 2 stores the value with bits 17:12 cleared. It then sends one request with hart index from bits 31:18, guest 0 and identity from bits 10:0.
- R11: If a software message and a qualifying source are both waiting, the software message is sent first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dom_en | input | 1 | Domain enable for source messages |
| src_en | input | NUM_SRC | Per-source enable |
| src_pend | input | NUM_SRC | Per-source pending |
| pend_clr | output | NUM_SRC | One-cycle pending clear for the issued source |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| req_valid | output | 1 | Write request valid |
| req_ready | input | 1 | Write request accepted when high with valid |
| req_addr | output | 64 | Write address |
| req_data | output | 32 | Write data (identity) |

## Verification
The software message path and the source path can want the single output slot in the same cycle. The bench provokes this by writing the message register at the clock edge where a source's pending bit also rises. It then judges the order in which the two requests appear, and checks the address and data of each. A configuration write that lands while a request is stalled is a second collision. The bench checks that the stalled address does not move, and that the following request uses the new configuration.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam logic [31:0] HI_VALID_MASK = 32'h9F77FFFF;
  localparam logic [31:0] GUEST_CLEAR   = 32'hFFFC0FFF;
  localparam int HART_W  = 14;
  localparam int GUEST_W = 6;
  localparam int IDENT_W = 11;

  typedef struct packed {
    logic [HART_W-1:0]  hart;
    logic [GUEST_W-1:0] guest;
    logic [IDENT_W-1:0] ident;
  } msg_t;
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs #(
  parameter int NUM_SRC  = 8,
  parameter int AW       = 6,
  parameter int TGT_BASE = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [AW-1:0]         addr,
  input  logic [31:0]           wdata,
  input  logic                  gen_take,
  output logic [31:0]           base_lo,
  output logic [31:0]           base_hi,
  output logic [31:0]           gen_word,
  output logic                  gen_req,
  output logic [NUM_SRC*32-1:0] tgt_flat,
  output logic [31:0]           rdata
);
  import msi_pkg::*;

  logic [31:0] lo_q, hi_q, gen_q;
  logic        gen_v;
  logic [31:0] tgt_q [NUM_SRC];
  logic        locked;

  assign locked = hi_q[31];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      gen_q <= '0;
      gen_v <= 1'b0;
    end else begin
      if (we && addr == AW'(0) && !locked) lo_q <= wdata;
      if (we && addr == AW'(1) && !locked) hi_q <= wdata & HI_VALID_MASK;
      if (we && addr == AW'(2)) begin
        gen_q <= wdata & GUEST_CLEAR;
        gen_v <= 1'b1;
      end else if (gen_take) begin
        gen_v <= 1'b0;
      end
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_tgt
    always_ff @(posedge clk) begin
      if (!rst_n) tgt_q[s] <= '0;
      else if (we && addr == AW'(TGT_BASE + s)) tgt_q[s] <= wdata;
    end
    assign tgt_flat[s*32 +: 32] = tgt_q[s];
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(0)) rdata = lo_q;
    else if (addr == AW'(1)) rdata = hi_q;
    else if (addr == AW'(2)) rdata = gen_q;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (addr == AW'(TGT_BASE + s)) rdata = tgt_q[s];
    end
  end

  assign base_lo  = lo_q;
  assign base_hi  = hi_q;
  assign gen_word = gen_q;
  assign gen_req  = gen_v;
endmodule

// File: rtl/msi_addr_calc.sv
module msi_addr_calc (
  input  logic [31:0] base_lo,
  input  logic [31:0] base_hi,
  input  logic [13:0] hart,
  input  logic [5:0]  guest,
  output logic [63:0] addr
);
  logic [4:0]  grp_shift;
  logic [2:0]  hrt_shift;
  logic [2:0]  grp_width;
  logic [3:0]  hrt_width;
  logic [63:0] grp_v, hrt_v, gst_v, ppn;

  always_comb begin
    grp_shift = base_hi[28:24];
    hrt_shift = base_hi[22:20];
    grp_width = base_hi[18:16];
    hrt_width = base_hi[15:12];
    grp_v = ({50'd0, hart} >> hrt_width) & ((64'd1 << grp_width) - 64'd1);
    hrt_v = {50'd0, hart} & ((64'd1 << hrt_width) - 64'd1);
    gst_v = {58'd0, guest} & ((64'd1 << hrt_shift) - 64'd1);
    ppn   = {20'd0, base_hi[11:0], base_lo}
          | (grp_v << (6'd12 + {1'b0, grp_shift}))
          | (hrt_v << hrt_shift)
          | gst_v;
    addr  = {ppn[51:0], 12'd0};
  end
endmodule

// File: rtl/msi_src_pick.sv
module msi_src_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  qual,
  output logic          hit,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (qual[i]) idx = IW'(i);
    end
    hit    = |qual;
    onehot = hit ? (N'(1) << idx) : '0;
  end
endmodule

// File: rtl/msi_addr_gen.sv
module msi_addr_gen #(
  parameter int NUM_SRC       = 8,
  parameter int MACHINE_LEVEL = 0,
  parameter int AW            = 6,
  parameter int TGT_BASE      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dom_en,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [NUM_SRC-1:0] src_pend,
  output logic [NUM_SRC-1:0] pend_clr,
  input  logic               cfg_we,
  input  logic [AW-1:0]      cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [63:0]        req_addr,
  output logic [31:0]        req_data
);
  import msi_pkg::*;
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [31:0]           cfg_lo, cfg_hi, gen_word;
  logic                  gen_req, gen_take;
  logic [NUM_SRC*32-1:0] tgt_flat;
  logic [NUM_SRC-1:0]    qual, sel_oh;
  logic                  sel_hit;
  logic [IW-1:0]         sel_idx;
  logic [31:0]           tgt_sel;
  msg_t                  msg;
  logic [63:0]           calc_addr;
  logic                  load;

  msi_cfg_regs #(.NUM_SRC(NUM_SRC), .AW(AW), .TGT_BASE(TGT_BASE)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .gen_take(gen_take), .base_lo(cfg_lo), .base_hi(cfg_hi), .gen_word(gen_word),
    .gen_req(gen_req), .tgt_flat(tgt_flat), .rdata(cfg_rdata)
  );

  assign qual = {NUM_SRC{dom_en}} & src_en & src_pend & ~NUM_SRC'(1);

  msi_src_pick #(.N(NUM_SRC)) pick_i (
    .qual(qual), .hit(sel_hit), .idx(sel_idx), .onehot(sel_oh)
  );

  assign tgt_sel = tgt_flat[sel_idx*32 +: 32];

  always_comb begin
    if (gen_req) begin
      msg.hart  = gen_word[31:18];
      msg.guest = '0;
      msg.ident = gen_word[10:0];
    end else begin
      msg.hart  = tgt_sel[31:18];
      msg.guest = (MACHINE_LEVEL != 0) ? '0 : tgt_sel[17:12];
      msg.ident = tgt_sel[10:0];
    end
  end

  msi_addr_calc calc_i (
    .base_lo(cfg_lo), .base_hi(cfg_hi), .hart(msg.hart), .guest(msg.guest),
    .addr(calc_addr)
  );

  assign load     = !req_valid && (gen_req || sel_hit);
  assign gen_take = load && gen_req;
  assign pend_clr = (load && !gen_req) ? sel_oh : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_data  <= '0;
    end else if (load) begin
      req_valid <= 1'b1;
      req_addr  <= calc_addr;
      req_data  <= {21'd0, msg.ident};
    end else if (req_ready) begin
      req_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/msi_addr_gen_chk.sv
module msi_addr_gen_chk #(
  parameter int NUM_SRC = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dom_en,
  input logic [NUM_SRC-1:0] src_en,
  input logic [NUM_SRC-1:0] src_pend,
  input logic [NUM_SRC-1:0] pend_clr,
  input logic               req_valid,
  input logic               req_ready,
  input logic [63:0]        req_addr,
  input logic [31:0]        req_data,
  input logic               hi_lock
);
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_data));
  // R5
  one_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_clr));
  // R5
  clear_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr != '0) |-> dom_en && ((pend_clr & ~(src_en & src_pend)) == '0));
  // R6
  clear_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr != '0) |=> req_valid);
  // R7
  no_src_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_clr[0]);
  // R2
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_lock |=> hi_lock);
  // R4
  data_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_data[31:11] == '0);
endmodule

bind msi_addr_gen msi_addr_gen_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk(clk), .rst_n(rst_n), .dom_en(dom_en), .src_en(src_en), .src_pend(src_pend),
  .pend_clr(pend_clr), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_data(req_data), .hi_lock(cfg_hi[31])
);

// File: tb/msi_addr_gen_tb.sv
`timescale 1ns/1ps
module msi_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dom_en;
  logic [7:0]  src_en, pend, pend_set, pend_clr, pend_clr_m;
  logic        cfg_we;
  logic [5:0]  cfg_addr;
  logic [31:0] cfg_wdata, rdata, rdata_m;
  logic        req_valid, req_valid_m, req_ready;
  logic [63:0] addr, addr_m;
  logic [31:0] data, data_m;

  int vec = 0;
  int mis = 0;
  logic [31:0] lo_m, hi_m, gen_m;
  logic [31:0] tgt_m [8];

  always #2 clk = ~clk;

  msi_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .dom_en(dom_en), .src_en(src_en), .src_pend(pend),
    .pend_clr(pend_clr), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(addr), .req_data(data)
  );

  msi_addr_gen #(.MACHINE_LEVEL(1)) dut_m_i (
    .clk(clk), .rst_n(rst_n), .dom_en(dom_en), .src_en(src_en), .src_pend(pend),
    .pend_clr(pend_clr_m), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rdata_m), .req_valid(req_valid_m), .req_ready(req_ready),
    .req_addr(addr_m), .req_data(data_m)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else pend <= (pend & ~pend_clr) | pend_set;
  end

  function automatic logic [63:0] f_addr(input logic [31:0] lo, input logic [31:0] hi,
                                         input int hart, input int guest);
    int gs, hs, gw, hw;
    longint unsigned grp, hl, ppn;
    gs = int'(hi[28:24]); hs = int'(hi[22:20]);
    gw = int'(hi[18:16]); hw = int'(hi[15:12]);
    grp = longint'((hart / (1 << hw)) % (1 << gw));
    hl  = longint'(hart % (1 << hw));
    ppn = {20'd0, hi[11:0], lo};
    ppn = ppn | (grp << (gs + 12)) | (hl << hs) | longint'(guest % (1 << hs));
    return ppn * 64'd4096;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vec++;
    if (act !== exp) begin
      mis++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 6'd0 && !hi_m[31]) lo_m = d;
    if (a == 6'd1 && !hi_m[31]) hi_m = d & 32'h9F77FFFF;
    if (a == 6'd2) gen_m = d & 32'hFFFC0FFF;
    if (a >= 6'd32 && a < 6'd40) tgt_m[a-6'd32] = d;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    cfg_addr = a;
    #1;
    chk(tag, {32'd0, rdata}, {32'd0, exp});
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk);
    pend_set = m;
    @(negedge clk);
    pend_set = '0;
  endtask

  task automatic expect_msg(input int hart, input int guest, input int ident, input string tag);
    int n = 0;
    while (!req_valid && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " valid"}, {63'd0, req_valid}, 64'd1);
    chk({tag, " addr"}, addr, f_addr(lo_m, hi_m, hart, guest));
    chk({tag, " data"}, {32'd0, data}, 64'(ident));
    chk({tag, " R9 machine addr"}, addr_m, f_addr(lo_m, hi_m, hart, 0));
    req_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic expect_src(input int s, input string tag);
    expect_msg(int'(tgt_m[s][31:18]), int'(tgt_m[s][17:12]), int'(tgt_m[s][10:0]), tag);
  endtask

  task automatic idle_check(input int cycles, input string tag);
    repeat (cycles) begin
      @(negedge clk);
      chk(tag, {63'd0, req_valid}, 64'd0);
    end
  endtask

  task automatic t_reset;
    rd(6'd0, 32'd0, "R1 reset lo");
    rd(6'd1, 32'd0, "R1 reset hi");
    rd(6'd2, 32'd0, "R1 reset gen");
    chk("R1 reset valid", {63'd0, req_valid}, 64'd0);
    chk("R5 reset clear", {56'd0, pend_clr}, 64'd0);
  endtask

  task automatic t_mask;
    wr(6'd1, 32'h7FFFFFFF);
    rd(6'd1, 32'h1F77FFFF, "R1 hi mask");
    for (int s = 1; s < 8; s++) begin
      wr(6'(32 + s), {14'(s * 1237 + 5), 6'(s * 11), 1'b0, 11'(s * 100 + 1)});
    end
    rd(6'd35, tgt_m[3], "R1 target readback");
  endtask

  task automatic t_addr;
    wr(6'd0, 32'h00080000);
    wr(6'd1, 32'h04322012);
    pulse(8'h04);
    expect_src(2, "R3 R4 cfg A src2");
    wr(6'd1, 32'h00570ABC);
    pulse(8'h80);
    expect_src(7, "R3 cfg B src7");
  endtask

  task automatic t_order;
    pulse(8'h64);
    expect_src(2, "R6 first");
    expect_src(5, "R6 second");
    expect_src(6, "R6 third");
    idle_check(3, "R6 drained");
    chk("R5 pending cleared", {56'd0, pend}, 64'd0);
  endtask

  task automatic t_gate;
    src_en = 8'hEF;
    pulse(8'h10);
    idle_check(6, "R5 src disabled");
    chk("R5 pending kept", {63'd0, pend[4]}, 64'd1);
    src_en = 8'hFF;
    dom_en = 1'b0;
    idle_check(6, "R5 domain off");
    dom_en = 1'b1;
    expect_src(4, "R5 domain on");
  endtask

  task automatic t_src0;
    pulse(8'h01);
    idle_check(6, "R7 source zero");
  endtask

  task automatic t_hold;
    logic [63:0] a0;
    int n = 0;
    a0 = f_addr(lo_m, hi_m, int'(tgt_m[3][31:18]), int'(tgt_m[3][17:12]));
    pulse(8'h08);
    while (!req_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    wr(6'd0, 32'h00C40000);
    repeat (3) begin
      @(negedge clk);
      chk("R8 held valid", {63'd0, req_valid}, 64'd1);
      chk("R8 held addr", addr, a0);
    end
    req_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_ready = 1'b0;
    pulse(8'h02);
    expect_src(1, "R8 new config used");
  endtask

  task automatic t_gen;
    logic [31:0] d = 32'hABCDEFFF;
    wr(6'd2, d);
    rd(6'd2, 32'hABCC0FFF, "R10 stored");
    expect_msg(int'(d[31:18]), 0, int'(d[10:0]), "R10 message");
    idle_check(3, "R10 single");
  endtask

  task automatic t_same;
    logic [31:0] d = 32'h0045A123;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'd2; cfg_wdata = d; pend_set = 8'h08;
    @(negedge clk);
    cfg_we = 1'b0; pend_set = '0;
    expect_msg(int'(d[31:18]), 0, int'(d[10:0]), "R11 gen first");
    expect_src(3, "R11 source second");
  endtask

  task automatic t_lock;
    logic [31:0] lo0, hi0;
    wr(6'd1, hi_m | 32'h80000000);
    lo0 = lo_m; hi0 = hi_m;
    wr(6'd0, 32'h12345678);
    wr(6'd1, 32'h00000000);
    rd(6'd0, lo0, "R2 lo locked");
    rd(6'd1, hi0, "R2 hi locked");
    pulse(8'h20);
    expect_src(5, "R2 locked config used");
  endtask

  initial begin
    rst_n = 1'b0; dom_en = 1'b1; src_en = 8'hFF; pend_set = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; req_ready = 1'b0;
    lo_m = '0; hi_m = '0; gen_m = '0;
    for (int s = 0; s < 8; s++) tgt_m[s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_addr();
    t_order();
    t_gate();
    t_src0();
    t_hold();
    t_gen();
    t_same();
    t_lock();
    $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mis++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  end
endmodule